// File: doc/BRIEF.md
# LIN Frame Controller

This block runs one node of a single-wire LIN bus, either as the master or as a slave. As master, it sends the frame header on command. The header is a long dominant break, the 0x55 sync byte and a protected identifier. A receive path parses every header on the line, whoever sent it, and reports a valid identifier. After that the host commands the node either to send a response or to collect one. A response is 1 to 8 data bytes followed by a checksum byte.

All serial timing comes from a bit-rate enable tick. The tick is one clock wide and occurs once per bit time. The line is driven and sampled once per tick, and the incoming bit stream is assumed to be already aligned to the tick. A 2-bit configuration input selects one of four modes:
- standard operation;
- operation without the checksum byte;
- operation with the response timeout switched off;
- a listening loopback.

Response bytes travel as parallel buffers, with byte k in bits 8k+7..8k. The command port is a plain strobe rather than a valid/ready stream. A command that is not accepted in the current phase is dropped, so there is no back-pressure. The host reads `busy` and the status flags to know when a new command will take effect.

Top module: `lin_frame_ctrl`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0, and all status flags and `rx_buf` are 0.
- R2: Command op 2'b01 (send header), accepted only when the node is idle, transmits 13 zero bits, one 1 bit, then the sync byte 0x55, then the protected identifier. Each byte goes out as a 0 start bit, eight data bits LSB first and a 1 stop bit. Between frames the line rests at 1.
- R3: The protected identifier is {P1, P0, id[5:0]}, where P0 = id0^id1^id2^id4 and P1 = ~(id1^id3^id4^id5). A received header with correct parity sets `id_ok` and loads `rx_id`. A header with wrong parity leaves `id_ok` at 0.
- R4: Command op 2'b10 (send response) transmits `cmd_len` bytes from `tx_buf`, then the checksum byte, then sets `tx_ok`. The checksum is the bitwise inverse of the 8-bit sum of the data bytes, where each carry out of bit 7 is added back into bit 0.
- R5: Command op 2'b11 (receive response) stores `cmd_len` received bytes into `rx_buf`. It then compares the next byte with the checksum. A match sets `rx_ok`; a mismatch sets `chk_err`.
- R6: With `cfg` = 2'b01, no checksum byte is sent or expected. `tx_ok` or `rx_ok` follows the last data byte.
- R7: A response phase that is still running after 14 × (data bytes + checksum byte) ticks sets `tout_err` and ends the frame. With `cfg` = 2'b10 this timeout never fires.
- R8: With `cfg` = 2'b11, `txd` stays at 1, the receiver hears the node's own transmitter, and `rxd` has no effect.
- R9: `busy` rises when a header or response command is accepted. It stays high from the header through the response, and falls only together with `tx_ok`, `rx_ok`, `chk_err` or `tout_err`. Receiving a header does not set it.
- R10: A send-header command issued while `busy` is high is ignored.
- R11: A header is recognised only after at least 11 consecutive zero bits, followed by the sync byte 0x55. A different sync byte leaves `id_ok` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| cfg | input | 2 | Mode: 00 standard, 01 no checksum, 10 no timeout, 11 listen |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 send header, 10 send response, 11 receive response |
| cmd_id | input | 6 | Identifier for send header |
| cmd_len | input | 4 | Data byte count, 1 to 8 |
| tx_buf | input | 64 | Response bytes to send |
| rxd | input | 1 | Serial line in |
| txd | output | 1 | Serial line out, 1 = recessive |
| busy | output | 1 | Frame in progress |
| id_ok | output | 1 | Valid header received |
| rx_id | output | 6 | Received identifier |
| tx_ok | output | 1 | Response sent |
| rx_ok | output | 1 | Response received with a good checksum |
| chk_err | output | 1 | Checksum mismatch |
| tout_err | output | 1 | Response timeout |
| rx_buf | output | 64 | Received response bytes |

## Verification
The hardest state to reach from the ports is a response that stalls partway through. The bench gets there by commanding a receive, feeding only the first byte and then holding the line recessive. In standard mode the frame must end with `tout_err`. With the timeout disabled, the same stall must leave `busy` high past the window, and the frame must then complete normally once the missing bytes arrive. Listening mode is the other hard case: the bench drives `rxd` dominant throughout, so a header can only be recognised through the internal loop.

// File: rtl/lin_pkg.sv
package lin_pkg;
  localparam logic [1:0] OP_TXH = 2'b01;
  localparam logic [1:0] OP_TXR = 2'b10;
  localparam logic [1:0] OP_RXR = 2'b11;
  localparam logic [1:0] CFG_NOCHK  = 2'b01;
  localparam logic [1:0] CFG_NOTOUT = 2'b10;
  localparam logic [1:0] CFG_LISTEN = 2'b11;
  localparam logic [7:0] SYNC_BYTE  = 8'h55;

  typedef enum logic [2:0] {FS_IDLE, FS_HDR, FS_WRESP, FS_RTX, FS_RRX} fstate_t;
  typedef enum logic [1:0] {HP_WAIT, HP_SYNC, HP_PID} hparse_t;

  function automatic logic [7:0] pid_of(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] add_ec(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'b0, s[8]};
  endfunction
endpackage

// File: rtl/lin_tx.sv
module lin_tx #(
  parameter int BRK_LEN = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ld_brk,
  input  logic       ld_byte,
  input  logic [7:0] byte_in,
  output logic       ready,
  output logic       line
);
  localparam int SW = BRK_LEN + 1;
  localparam int CW = $clog2(SW + 1);

  logic [SW-1:0] sh;
  logic [CW-1:0] cnt;

  assign ready = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      cnt  <= '0;
      line <= 1'b1;
    end else if (ld_brk) begin
      sh  <= {1'b1, {BRK_LEN{1'b0}}};
      cnt <= CW'(SW);
    end else if (ld_byte) begin
      sh  <= SW'({1'b1, byte_in, 1'b0});
      cnt <= CW'(10);
    end else if (tick && cnt != '0) begin
      line <= sh[0];
      sh   <= sh >> 1;
      cnt  <= cnt - CW'(1);
    end
  end

  // R2
  idle_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> line);
  // R2
  load_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_brk || ld_byte) |-> ready);
endmodule

// File: rtl/lin_rx.sv
module lin_rx #(
  parameter int BRK_MIN = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_in,
  output logic       byte_vld,
  output logic [7:0] byte_out,
  output logic       brk
);
  localparam int ZW = $clog2(BRK_MIN + 1);
  typedef enum logic [1:0] {RS_IDLE, RS_DATA, RS_STOP, RS_WAITH} rstate_t;

  rstate_t       rs;
  logic [7:0]    sh;
  logic [2:0]    bc;
  logic [ZW-1:0] zc;

  assign byte_out = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs <= RS_IDLE; sh <= '0; bc <= '0; zc <= '0;
      byte_vld <= 1'b0; brk <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      brk      <= 1'b0;
      if (tick) begin
        if (!line_in) begin
          if (zc != ZW'(BRK_MIN)) zc <= zc + ZW'(1);
        end else begin
          if (zc == ZW'(BRK_MIN)) brk <= 1'b1;
          zc <= '0;
        end
        case (rs)
          RS_IDLE:  if (!line_in) begin rs <= RS_DATA; bc <= '0; end
          RS_DATA: begin
            sh <= {line_in, sh[7:1]};
            bc <= bc + 3'd1;
            if (bc == 3'd7) rs <= RS_STOP;
          end
          RS_STOP: begin
            if (line_in) begin byte_vld <= 1'b1; rs <= RS_IDLE; end
            else rs <= RS_WAITH;
          end
          default: if (line_in) rs <= RS_IDLE;
        endcase
      end
    end
  end

  // R11
  brk_not_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !byte_vld);
  // R5
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/lin_frame_ctrl.sv
module lin_frame_ctrl
  import lin_pkg::*;
#(
  parameter int MAXLEN        = 8,
  parameter int BRK_LEN       = 13,
  parameter int BRK_MIN       = 11,
  parameter int TOUT_PER_BYTE = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic [1:0]          cfg,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [5:0]          cmd_id,
  input  logic [3:0]          cmd_len,
  input  logic [MAXLEN*8-1:0] tx_buf,
  input  logic                rxd,
  output logic                txd,
  output logic                busy,
  output logic                id_ok,
  output logic [5:0]          rx_id,
  output logic                tx_ok,
  output logic                rx_ok,
  output logic                chk_err,
  output logic                tout_err,
  output logic [MAXLEN*8-1:0] rx_buf
);
  localparam int LENW = 4;
  localparam int IW   = $clog2(MAXLEN);
  localparam int TW   = $clog2(TOUT_PER_BYTE * (MAXLEN + 1) + 1);

  fstate_t        st;
  hparse_t        hp;
  logic [LENW-1:0] bidx, len_q;
  logic [7:0]     pid_q, acc, tx_byte, rx_byte;
  logic [TW-1:0]  tcnt, lim;
  logic [7:0]     txb [MAXLEN];
  logic [7:0]     rxb [MAXLEN];
  logic tx_rdy, tx_line, tx_ld_brk, tx_ld_byte, rx_in, rx_vld, rx_brk;
  logic chk_on, tout_on, listen, acc_hdr, acc_rsp, tout_hit;

  for (genvar g = 0; g < MAXLEN; g++) begin : g_buf
    assign txb[g] = tx_buf[g*8 +: 8];
    assign rx_buf[g*8 +: 8] = rxb[g];
  end

  assign chk_on  = (cfg != CFG_NOCHK);
  assign tout_on = (cfg != CFG_NOTOUT);
  assign listen  = (cfg == CFG_LISTEN);
  assign rx_in   = listen ? tx_line : rxd;
  assign txd     = listen ? 1'b1 : tx_line;
  assign busy    = (st != FS_IDLE);
  assign lim     = (TW'(len_q) + TW'(chk_on)) * TW'(TOUT_PER_BYTE);
  assign tout_hit = bit_tick && tout_on && (tcnt + TW'(1) >= lim);

  assign acc_hdr = cmd_valid && cmd_op == OP_TXH && st == FS_IDLE;
  assign acc_rsp = cmd_valid && (cmd_op == OP_TXR || cmd_op == OP_RXR)
                   && (st == FS_IDLE || st == FS_WRESP);

  assign tx_ld_brk  = tx_rdy && st == FS_HDR && bidx == '0;
  assign tx_ld_byte = tx_rdy && ((st == FS_HDR && (bidx == LENW'(1) || bidx == LENW'(2)))
                     || (st == FS_RTX && (bidx < len_q || (bidx == len_q && chk_on))));
  always_comb begin
    if (st == FS_HDR) tx_byte = (bidx == LENW'(1)) ? SYNC_BYTE : pid_q;
    else              tx_byte = (bidx == len_q) ? ~acc : txb[bidx[IW-1:0]];
  end

  lin_tx #(.BRK_LEN(BRK_LEN)) u_tx (
    .clk, .rst_n, .tick(bit_tick), .ld_brk(tx_ld_brk), .ld_byte(tx_ld_byte),
    .byte_in(tx_byte), .ready(tx_rdy), .line(tx_line));

  lin_rx #(.BRK_MIN(BRK_MIN)) u_rx (
    .clk, .rst_n, .tick(bit_tick), .line_in(rx_in),
    .byte_vld(rx_vld), .byte_out(rx_byte), .brk(rx_brk));

  // frame sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FS_IDLE; bidx <= '0; len_q <= '0; pid_q <= '0; acc <= '0; tcnt <= '0;
      tx_ok <= 1'b0; rx_ok <= 1'b0; chk_err <= 1'b0; tout_err <= 1'b0;
      for (int i = 0; i < MAXLEN; i++) rxb[i] <= '0;
    end else if (acc_hdr || acc_rsp) begin
      tx_ok <= 1'b0; rx_ok <= 1'b0; chk_err <= 1'b0; tout_err <= 1'b0;
      bidx <= '0; acc <= '0; tcnt <= '0;
      if (acc_hdr) begin
        st <= FS_HDR; pid_q <= pid_of(cmd_id);
      end else begin
        st <= (cmd_op == OP_TXR) ? FS_RTX : FS_RRX;
        len_q <= cmd_len;
      end
    end else begin
      case (st)
        FS_HDR: begin
          if (tx_ld_brk || tx_ld_byte) bidx <= bidx + LENW'(1);
          else if (tx_rdy && bidx == LENW'(3)) st <= FS_WRESP;
        end
        FS_RTX, FS_RRX: begin
          if (bit_tick) tcnt <= tcnt + TW'(1);
          if (tout_hit) begin
            tout_err <= 1'b1; st <= FS_IDLE;
          end else if (st == FS_RTX) begin
            if (tx_ld_byte) begin
              bidx <= bidx + LENW'(1);
              if (bidx < len_q) acc <= add_ec(acc, tx_byte);
            end else if (tx_rdy) begin
              tx_ok <= 1'b1; st <= FS_IDLE;
            end
          end else if (rx_vld) begin
            if (bidx < len_q) begin
              rxb[bidx[IW-1:0]] <= rx_byte;
              acc  <= add_ec(acc, rx_byte);
              bidx <= bidx + LENW'(1);
              if (bidx + LENW'(1) == len_q && !chk_on) begin
                rx_ok <= 1'b1; st <= FS_IDLE;
              end
            end else begin
              if (rx_byte == ~acc) rx_ok <= 1'b1;
              else chk_err <= 1'b1;
              st <= FS_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // header parser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp <= HP_WAIT; id_ok <= 1'b0; rx_id <= '0;
    end else if (rx_brk || acc_hdr) begin
      id_ok <= 1'b0;
      if (rx_brk) hp <= HP_SYNC;
    end else if (rx_vld) begin
      case (hp)
        HP_SYNC: hp <= (rx_byte == SYNC_BYTE) ? HP_PID : HP_WAIT;
        HP_PID: begin
          if (pid_of(rx_byte[5:0]) == rx_byte) begin
            id_ok <= 1'b1; rx_id <= rx_byte[5:0];
          end
          hp <= HP_WAIT;
        end
        default: ;
      endcase
    end
  end

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (tx_ok || rx_ok || chk_err || tout_err));
  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_ok, rx_ok, chk_err, tout_err}));
  // R7
  tout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout_err) |-> $past(cfg) != CFG_NOTOUT);
  // R10
  hdr_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != FS_WRESP) |=> st != FS_HDR || $past(st) == FS_HDR);
endmodule

// File: tb/tb_lin_frame_ctrl.sv
module tb_lin_frame_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic [1:0] cfg = 2'b00;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [5:0] cmd_id = '0;
  logic [3:0] cmd_len = '0;
  logic [63:0] tx_buf = '0;
  logic rxd_drv = 1'b1, loop_en = 1'b0;
  logic rxd, txd, busy, id_ok, tx_ok, rx_ok, chk_err, tout_err;
  logic [5:0] rx_id;
  logic [63:0] rx_buf;
  int n_chk = 0, n_bad = 0, tdiv = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    bit_tick = (tdiv == 0);
  end
  assign rxd = loop_en ? txd : rxd_drv;

  lin_frame_ctrl dut (
    .clk, .rst_n, .bit_tick, .cfg, .cmd_valid, .cmd_op, .cmd_id, .cmd_len,
    .tx_buf, .rxd, .txd, .busy, .id_ok, .rx_id, .tx_ok, .rx_ok, .chk_err,
    .tout_err, .rx_buf);

  function automatic logic [7:0] exp_pid(input logic [5:0] id);
    return {~(id[1]^id[3]^id[4]^id[5]), id[0]^id[1]^id[2]^id[4], id};
  endfunction

  function automatic logic [7:0] exp_sum(input logic [63:0] b, input int n);
    int s = 0;
    for (int i = 0; i < n; i++) begin
      s = s + b[i*8 +: 8];
      if (s > 255) s = s - 255;
    end
    return ~s[7:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next_tick();
    @(posedge clk);
    while (!bit_tick) @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) next_tick();
  endtask

  task automatic issue(input logic [1:0] op, input logic [5:0] id, input logic [3:0] len);
    cmd_op = op; cmd_id = id; cmd_len = len; cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    rxd_drv = b;
    next_tick();
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(1'b1);
  endtask

  task automatic send_hdr(input logic [7:0] sync, input logic [7:0] pid);
    for (int i = 0; i < 13; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_byte(sync);
    send_byte(pid);
    next_tick();
  endtask

  task automatic rd_brk(output int n);
    int w = 0;
    next_tick();
    while (txd !== 1'b0 && w < 60) begin next_tick(); w++; end
    n = 0;
    while (txd === 1'b0 && n < 40) begin n++; next_tick(); end
  endtask

  task automatic rd_byte(output logic [7:0] b, output logic stop_ok);
    int w = 0;
    next_tick();
    while (txd !== 1'b0 && w < 60) begin next_tick(); w++; end
    for (int i = 0; i < 8; i++) begin next_tick(); b[i] = txd; end
    next_tick();
    stop_ok = txd;
  endtask

  task automatic t_reset();
    check("R1 txd", txd, 1);
    check("R1 busy", busy, 0);
    check("R1 flags", {id_ok, tx_ok, rx_ok, chk_err, tout_err}, 0);
    check("R1 rx_buf", rx_buf, 0);
  endtask

  task automatic t_master();
    int n; logic [7:0] b; logic s;
    cfg = 2'b00; loop_en = 1'b1;
    issue(2'b01, 6'h3C, 4'd0);
    check("R9 busy on header cmd", busy, 1);
    rd_brk(n);
    check("R2 break length", n, 13);
    rd_byte(b, s);
    check("R2 sync byte", {s, b}, {1'b1, 8'h55});
    rd_byte(b, s);
    check("R3 pid", {s, b}, {1'b1, exp_pid(6'h3C)});
    ticks(2);
    check("R3 id_ok", id_ok, 1);
    check("R3 rx_id", rx_id, 6'h3C);
    check("R9 busy after header", busy, 1);
    tx_buf = '0; tx_buf[7:0] = 8'hA5; tx_buf[15:8] = 8'h7F;
    issue(2'b10, 6'h0, 4'd2);
    rd_byte(b, s); check("R4 data0", b, 8'hA5);
    rd_byte(b, s); check("R4 data1", b, 8'h7F);
    rd_byte(b, s); check("R4 checksum", b, 8'hDA);
    ticks(2);
    check("R4 tx_ok", tx_ok, 1);
    check("R9 busy cleared", busy, 0);
    loop_en = 1'b0;
  endtask

  task automatic t_slave_rx();
    logic [63:0] d;
    cfg = 2'b00; loop_en = 1'b0;
    next_tick();
    send_hdr(8'h55, exp_pid(6'h12));
    check("R3 slave id_ok", id_ok, 1);
    check("R3 slave rx_id", rx_id, 6'h12);
    check("R9 header does not set busy", busy, 0);
    d = '0; d[7:0] = 8'h11; d[15:8] = 8'h22; d[23:16] = 8'h33;
    issue(2'b11, 6'h0, 4'd3);
    check("R9 busy on receive cmd", busy, 1);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    send_byte(exp_sum(d, 3));
    next_tick();
    check("R5 rx_ok", {rx_ok, chk_err}, 2'b10);
    check("R5 rx_buf", rx_buf, d);
    check("R9 busy end", busy, 0);
  endtask

  task automatic t_badsum();
    issue(2'b11, 6'h0, 4'd1);
    send_byte(8'h40); send_byte(8'h00);
    next_tick();
    check("R5 chk_err", {rx_ok, chk_err}, 2'b01);
  endtask

  task automatic t_badhdr();
    send_hdr(8'h55, exp_pid(6'h21) ^ 8'h80);
    check("R3 bad parity no id_ok", id_ok, 0);
    send_hdr(8'h54, exp_pid(6'h21));
    check("R11 bad sync no id_ok", id_ok, 0);
    send_hdr(8'h55, exp_pid(6'h21));
    check("R11 good header id_ok", id_ok, 1);
  endtask

  task automatic t_nochk();
    logic [7:0] b; logic s; int z = 0;
    cfg = 2'b01;
    tx_buf = '0; tx_buf[7:0] = 8'h81;
    issue(2'b10, 6'h0, 4'd1);
    rd_byte(b, s);
    check("R6 data byte", b, 8'h81);
    for (int i = 0; i < 12; i++) begin next_tick(); if (txd !== 1'b1) z++; end
    check("R6 no checksum sent", z, 0);
    check("R6 tx_ok", tx_ok, 1);
    issue(2'b11, 6'h0, 4'd2);
    send_byte(8'hC3); send_byte(8'h3C);
    next_tick();
    check("R6 rx_ok without checksum", {rx_ok, busy}, 2'b10);
    check("R6 rx bytes", rx_buf[15:0], 16'h3CC3);
    cfg = 2'b00;
  endtask

  task automatic t_timeout();
    logic [63:0] d;
    cfg = 2'b00;
    issue(2'b11, 6'h0, 4'd2);
    send_byte(8'h05);
    ticks(40);
    check("R7 tout_err", {tout_err, busy}, 2'b10);
    cfg = 2'b10;
    issue(2'b11, 6'h0, 4'd2);
    send_byte(8'h05);
    ticks(40);
    check("R7 timeout disabled", {tout_err, busy}, 2'b01);
    d = '0; d[7:0] = 8'h05; d[15:8] = 8'h06;
    send_byte(8'h06); send_byte(exp_sum(d, 2));
    next_tick();
    check("R7 late finish rx_ok", {rx_ok, busy}, 2'b10);
    cfg = 2'b00;
  endtask

  task automatic t_listen();
    int z = 0;
    cfg = 2'b11; loop_en = 1'b0; rxd_drv = 1'b0;
    issue(2'b01, 6'h15, 4'd0);
    for (int i = 0; i < 60; i++) begin next_tick(); if (txd !== 1'b1) z++; end
    check("R8 txd held recessive", z, 0);
    check("R8 internal loop id", {id_ok, rx_id}, {1'b1, 6'h15});
    tx_buf = '0; tx_buf[7:0] = 8'h5A;
    issue(2'b10, 6'h0, 4'd1);
    ticks(30);
    check("R8 tx_ok in listen", {tx_ok, busy}, 2'b10);
    rxd_drv = 1'b1;
    next_tick();
    cfg = 2'b00;
  endtask

  task automatic t_ignore();
    int n, z = 0; logic [7:0] b; logic s;
    cfg = 2'b00; loop_en = 1'b1;
    issue(2'b01, 6'h01, 4'd0);
    issue(2'b01, 6'h02, 4'd0);
    rd_brk(n);
    rd_byte(b, s);
    rd_byte(b, s);
    check("R10 first id kept", b, exp_pid(6'h01));
    ticks(2);
    issue(2'b01, 6'h03, 4'd0);
    for (int i = 0; i < 20; i++) begin next_tick(); if (txd !== 1'b1) z++; end
    check("R10 header cmd ignored while busy", {z[7:0], busy}, {8'd0, 1'b1});
    tx_buf = '0;
    issue(2'b10, 6'h0, 4'd1);
    ticks(30);
    check("R9 master frame done", {tx_ok, busy}, 2'b10);
    loop_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_master();
    t_slave_rx();
    t_badsum();
    t_badhdr();
    t_nochk();
    t_timeout();
    t_listen();
    t_ignore();
    finish_run();
  end
endmodule